// File: doc/BRIEF.md
# I2C Byte-Command Master

This block is an I2C bus master that software drives one byte at a time through a small synchronous register port. Software loads a bit-time divider and switches the core on. It puts an outgoing byte in the data register and writes a command word. In one write, that word can ask for a start (or repeated start) condition, a byte written to the bus or read from it, a stop condition, and the acknowledge level to return after a read. The block then runs the whole sequence on two open-drain lines and reports the outcome in a status word.

Each SCL bit is split into five equal phases, and each phase lasts `divider + 1` system clocks. The command bits are not stored. They are consumed on the write, so software never has to clear them. When a command finishes or arbitration is lost, an interrupt-pending flag is set. The flag drives an interrupt line while interrupts are enabled, and software clears it with an acknowledge bit in the command word.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, every readable register returns 0x00, `irq` is low and neither line is driven low.
- R2: The divider low byte (offset 0x0) and high byte (offset 0x2) read back as written. The control register (offset 0x4) reads back bit 7 (core on) and bit 6 (interrupt enable), with all other bits zero. Status bits 4..2 always read zero.
- R3: A command (offset 0x8 write) with bit 7 (start) and bit 4 (write) set produces a start condition, sends the data-register byte MSB first and samples the 9th bit. Status bit 7 then reads 0 if the slave pulled SDA low and 1 if it did not.
- R4: A command with bit 5 (read) shifts in 8 bits MSB first and makes them readable at offset 0x6. On the 9th bit the master drives SDA low if command bit 3 is 0 and releases it if bit 3 is 1.
- R5: Status bit 6 goes high once a start condition is seen on the bus and low once a stop condition is seen. Command bit 6 ends the sequence with a stop condition that leaves both lines released.
- R6: Status bit 1 is high from the cycle after an accepted command write until its last step ends. Command bits need no clearing: a following command is accepted without an intervening write.
- R7: Status bit 0 is set when a command finishes. `irq` equals that bit ANDed with the interrupt enable. A command write with bit 0 set clears status bit 0.
- R8: Within a byte, consecutive SCL rising edges are 5 × (divider + 1) + 2 clocks apart.
- R9: If the master releases SDA during a written bit but samples it low while SCL is high, it releases both lines, ends the command, and sets status bit 5 and status bit 0. The next command carrying a start bit clears status bit 5.
- R10: While control bit 7 is 0, command writes are ignored: status bit 1 stays 0 and both lines stay released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data for `reg_addr` |
| irq | output | 1 | Interrupt request |
| scl_i | input | 1 | Sampled SCL line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_i | input | 1 | Sampled SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
A behavioural slave on the bench bus receives the bytes, acknowledges or refuses them, and serves read data. This covers a slave that refuses, which a master that ignored the 9th bit would report as acknowledged. It also covers a read where the acknowledge level flips between bytes, which a master that drove a fixed level would get wrong on the last byte. The bench forces arbitration loss by holding SDA low under a byte of all ones. A design that missed the loss would keep clocking and leave its status clear. A design that failed to release the lines would hold SCL, which shows up in the line checks. The bench also measures the SCL spacing against the divider and attempts commands while the core is off.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [2:0] {
    BIT_IDLE, BIT_START, BIT_STOP, BIT_WRITE, BIT_READ
  } bit_cmd_e;

  // command word bit positions
  localparam int CMD_START = 7;
  localparam int CMD_STOP  = 6;
  localparam int CMD_RD    = 5;
  localparam int CMD_WR    = 4;
  localparam int CMD_NACK  = 3;
  localparam int CMD_IACK  = 0;

  // control word bit positions
  localparam int CTL_EN = 7;
  localparam int CTL_IE = 6;

  localparam logic [3:0] OFS_DIV_LO = 4'h0;
  localparam logic [3:0] OFS_DIV_HI = 4'h2;
  localparam logic [3:0] OFS_CTRL   = 4'h4;
  localparam logic [3:0] OFS_DATA   = 4'h6;
  localparam logic [3:0] OFS_CMDST  = 4'h8;
endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES < 2) begin : g_bad
      initial $error("i2cm_sync needs at least two stages");
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cm_bit_eng.sv
module i2cm_bit_eng
  import i2cm_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [DIV_W-1:0] divider,
  input  logic             go,
  input  bit_cmd_e         cmd,
  input  logic             din,
  output logic             ready,
  output logic             done,
  output logic             dout,
  output logic             lost,
  output logic             bus_busy,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_oe,
  output logic             sda_oe
);
  localparam logic [2:0] LAST_PH   = 3'd4;
  localparam logic [2:0] SAMPLE_PH = 3'd3;

  logic scl_s, sda_s, scl_d, sda_d;
  i2cm_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (.clk(clk), .rst(rst), .d(scl_i), .q(scl_s));
  i2cm_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (.clk(clk), .rst(rst), .d(sda_i), .q(sda_s));

  always_ff @(posedge clk) begin
    if (rst) {scl_d, sda_d} <= 2'b11;
    else     {scl_d, sda_d} <= {scl_s, sda_s};
  end

  wire start_seen = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_seen  = scl_s & scl_d & ~sda_d & sda_s;

  always_ff @(posedge clk) begin
    if (rst)             bus_busy <= 1'b0;
    else if (start_seen) bus_busy <= 1'b1;
    else if (stop_seen)  bus_busy <= 1'b0;
  end

  bit_cmd_e         cur;
  logic [2:0]       ph;
  logic [DIV_W-1:0] cnt;
  logic             tx;
  logic             scl_n, sda_n;

  wire tick   = (cnt == divider);
  wire sample = tick && (ph == SAMPLE_PH);
  wire lose   = (cur == BIT_WRITE && sample && tx && !sda_s) ||
                ((cur == BIT_WRITE || cur == BIT_READ) && stop_seen);

  assign ready = (cur == BIT_IDLE);

  // line targets per phase; 1 = pull low
  always_comb begin
    scl_n = scl_oe;
    sda_n = sda_oe;
    case (cur)
      BIT_START: begin
        sda_n = (ph >= 3'd2);
        scl_n = (ph == 3'd0) ? scl_oe : (ph == LAST_PH);
      end
      BIT_STOP: begin
        sda_n = (ph <= 3'd2);
        scl_n = (ph == 3'd0);
      end
      BIT_WRITE, BIT_READ: begin
        sda_n = ~tx;
        scl_n = (ph == 3'd0) || (ph == LAST_PH);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cur    <= BIT_IDLE;
      ph     <= '0;
      cnt    <= '0;
      tx     <= 1'b1;
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
      done   <= 1'b0;
      lost   <= 1'b0;
      dout   <= 1'b0;
    end else begin
      done <= 1'b0;
      lost <= 1'b0;
      if (cur == BIT_IDLE) begin
        cnt <= '0;
        ph  <= '0;
        if (go) begin
          cur <= cmd;
          tx  <= (cmd == BIT_WRITE) ? din : 1'b1;
        end
      end else if (lose) begin
        cur    <= BIT_IDLE;
        lost   <= 1'b1;
        scl_oe <= 1'b0;
        sda_oe <= 1'b0;
      end else begin
        scl_oe <= scl_n;
        sda_oe <= sda_n;
        if (sample) dout <= sda_s;
        if (tick) begin
          cnt <= '0;
          if (ph == LAST_PH) begin
            cur  <= BIT_IDLE;
            done <= 1'b1;
          end else begin
            ph <= ph + 3'd1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/i2cm_byte_eng.sv
module i2cm_byte_eng
  import i2cm_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              go,
  input  logic              f_start,
  input  logic              f_stop,
  input  logic              f_rd,
  input  logic              f_wr,
  input  logic              f_nack,
  input  logic [BYTE_W-1:0] txd,
  output logic [BYTE_W-1:0] rxd,
  output logic              rxack,
  output logic              done,
  output logic              lost,
  output logic              bit_go,
  output bit_cmd_e          bit_cmd,
  output logic              bit_din,
  input  logic              bit_ready,
  input  logic              bit_done,
  input  logic              bit_dout,
  input  logic              bit_lost
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_BITS, ST_ACK, ST_STOP} step_e;

  step_e             st;
  logic              issued, do_wr, do_xfer, do_stop, nack_q;
  logic [CNT_W-1:0]  nbit;
  logic [BYTE_W-1:0] sr;

  always_comb begin
    bit_go  = (st != ST_IDLE) && !issued && bit_ready;
    bit_din = (st == ST_ACK) ? nack_q : sr[BYTE_W-1];
    case (st)
      ST_START: bit_cmd = BIT_START;
      ST_BITS:  bit_cmd = do_wr ? BIT_WRITE : BIT_READ;
      ST_ACK:   bit_cmd = do_wr ? BIT_READ : BIT_WRITE;
      ST_STOP:  bit_cmd = BIT_STOP;
      default:  bit_cmd = BIT_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      st      <= ST_IDLE;
      issued  <= 1'b0;
      do_wr   <= 1'b0;
      do_xfer <= 1'b0;
      do_stop <= 1'b0;
      nack_q  <= 1'b0;
      nbit    <= '0;
      sr      <= '0;
      rxd     <= '0;
      rxack   <= 1'b0;
      done    <= 1'b0;
      lost    <= 1'b0;
    end else begin
      done <= 1'b0;
      lost <= 1'b0;
      if (st == ST_IDLE) begin
        if (go) begin
          do_wr   <= f_wr;
          do_xfer <= f_wr | f_rd;
          do_stop <= f_stop;
          nack_q  <= f_nack;
          sr      <= txd;
          nbit    <= '0;
          issued  <= 1'b0;
          st      <= f_start ? ST_START : ((f_wr | f_rd) ? ST_BITS : ST_STOP);
        end
      end else if (bit_lost) begin
        st     <= ST_IDLE;
        issued <= 1'b0;
        lost   <= 1'b1;
      end else begin
        if (bit_go) issued <= 1'b1;
        if (bit_done) begin
          issued <= 1'b0;
          case (st)
            ST_START: begin
              if (do_xfer)      st <= ST_BITS;
              else if (do_stop) st <= ST_STOP;
              else begin st <= ST_IDLE; done <= 1'b1; end
            end
            ST_BITS: begin
              sr   <= {sr[BYTE_W-2:0], bit_dout};
              nbit <= nbit + 1'b1;
              if (nbit == LAST_BIT) begin
                st <= ST_ACK;
                if (!do_wr) rxd <= {sr[BYTE_W-2:0], bit_dout};
              end
            end
            ST_ACK: begin
              if (do_wr) rxack <= bit_dout;
              if (do_stop) st <= ST_STOP;
              else begin st <= ST_IDLE; done <= 1'b1; end
            end
            default: begin
              st   <= ST_IDLE;
              done <= 1'b1;
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cm_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq,
  input  logic              scl_i,
  output logic              scl_oe,
  input  logic              sda_i,
  output logic              sda_oe
);
  localparam int REG_W = 8;
  localparam int DIV_W = 2 * REG_W;

  logic [REG_W-1:0] div_lo, div_hi, txd;
  logic             en_q, ie_q, tip, ip, al_q;

  logic [REG_W-1:0] rxd;
  logic             rxack, byte_done, byte_lost, bus_busy;
  logic             bit_go, bit_din, bit_ready, bit_done, bit_dout, bit_lost;
  bit_cmd_e         bit_cmd;

  wire cmd_wr  = reg_we && (reg_addr == ADDR_W'(OFS_CMDST));
  wire cmd_any = reg_wdata[CMD_START] | reg_wdata[CMD_STOP] |
                 reg_wdata[CMD_RD]    | reg_wdata[CMD_WR];
  wire launch  = cmd_wr && en_q && cmd_any && !tip;

  i2cm_bit_eng #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_bit (
    .clk(clk), .rst(rst), .clr(!en_q), .divider({div_hi, div_lo}),
    .go(bit_go), .cmd(bit_cmd), .din(bit_din), .ready(bit_ready),
    .done(bit_done), .dout(bit_dout), .lost(bit_lost), .bus_busy(bus_busy),
    .scl_i(scl_i), .sda_i(sda_i), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  i2cm_byte_eng #(.BYTE_W(REG_W)) u_byte (
    .clk(clk), .rst(rst), .clr(!en_q), .go(launch),
    .f_start(reg_wdata[CMD_START]), .f_stop(reg_wdata[CMD_STOP]),
    .f_rd(reg_wdata[CMD_RD]), .f_wr(reg_wdata[CMD_WR]), .f_nack(reg_wdata[CMD_NACK]),
    .txd(txd), .rxd(rxd), .rxack(rxack), .done(byte_done), .lost(byte_lost),
    .bit_go(bit_go), .bit_cmd(bit_cmd), .bit_din(bit_din), .bit_ready(bit_ready),
    .bit_done(bit_done), .bit_dout(bit_dout), .bit_lost(bit_lost)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      div_lo <= '0;
      div_hi <= '0;
      txd    <= '0;
      en_q   <= 1'b0;
      ie_q   <= 1'b0;
      tip    <= 1'b0;
      ip     <= 1'b0;
      al_q   <= 1'b0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          ADDR_W'(OFS_DIV_LO): div_lo <= reg_wdata;
          ADDR_W'(OFS_DIV_HI): div_hi <= reg_wdata;
          ADDR_W'(OFS_CTRL): begin
            en_q <= reg_wdata[CTL_EN];
            ie_q <= reg_wdata[CTL_IE];
          end
          ADDR_W'(OFS_DATA): txd <= reg_wdata;
          default: ;
        endcase
      end
      if (launch) begin
        tip <= 1'b1;
        if (reg_wdata[CMD_START]) al_q <= 1'b0;
      end
      if (byte_done || byte_lost) begin
        tip <= 1'b0;
        ip  <= 1'b1;
      end else if (cmd_wr && reg_wdata[CMD_IACK]) begin
        ip <= 1'b0;
      end
      if (byte_lost) al_q <= 1'b1;
      if (!en_q)     tip  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        ADDR_W'(OFS_DIV_LO): reg_rdata <= div_lo;
        ADDR_W'(OFS_DIV_HI): reg_rdata <= div_hi;
        ADDR_W'(OFS_CTRL):   reg_rdata <= {en_q, ie_q, 6'b0};
        ADDR_W'(OFS_DATA):   reg_rdata <= rxd;
        ADDR_W'(OFS_CMDST):  reg_rdata <= {rxack, bus_busy, al_q, 3'b000, tip, ip};
        default:             reg_rdata <= '0;
      endcase
    end
  end

  assign irq = ip & ie_q;
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [7:0]        reg_wdata,
  input logic              en_q,
  input logic              tip,
  input logic              ip,
  input logic              al_q,
  input logic              launch,
  input logic              byte_done,
  input logic              byte_lost,
  input logic              scl_oe,
  input logic              sda_oe
);
  localparam logic [ADDR_W-1:0] CMD_OFS = ADDR_W'(4'h8);

  assert_launch_tip_R6: assert property (@(posedge clk) disable iff (rst)
    launch |=> tip);

  assert_done_sets_ip_R7: assert property (@(posedge clk) disable iff (rst)
    byte_done |=> ip);

  assert_iack_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == CMD_OFS && reg_wdata[0] && !byte_done && !byte_lost) |=> !ip);

  assert_lost_flags_R9: assert property (@(posedge clk) disable iff (rst)
    byte_lost |=> (al_q && ip && !tip));

  assert_off_no_tip_R10: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !tip);

  assert_off_lines_R10: assert property (@(posedge clk) disable iff (rst)
    (!en_q && $past(!en_q)) |=> (!scl_oe && !sda_oe));
endmodule

bind i2c_byte_master i2cm_checker #(.ADDR_W(ADDR_W)) u_i2cm_checker (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .en_q(en_q), .tip(tip), .ip(ip), .al_q(al_q), .launch(launch),
  .byte_done(byte_done), .byte_lost(byte_lost), .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/test_i2c_byte_master.sv
module test_i2c_byte_master;
  localparam int DIV    = 1;
  localparam int BIT_T  = 5 * (DIV + 1) + 2;
  localparam logic [3:0] A_LO = 4'h0, A_HI = 4'h2, A_CTL = 4'h4, A_DAT = 4'h6, A_CMD = 4'h8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic       we = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wd = '0;
  logic [7:0] rdata;
  logic       irq, m_scl_oe, m_sda_oe;
  logic       s_sda_oe = 1'b0;
  logic       jam = 1'b0;
  logic [7:0] slv_tx = 8'h96;
  logic       ack_en = 1'b1;

  wire scl_w = ~m_scl_oe;
  wire sda_w = ~(m_sda_oe | s_sda_oe | jam);

  i2c_byte_master i_i2c_byte_master (
    .clk(clk), .rst(rst), .reg_we(we), .reg_addr(addr), .reg_wdata(wd),
    .reg_rdata(rdata), .irq(irq), .scl_i(scl_w), .scl_oe(m_scl_oe),
    .sda_i(sda_w), .sda_oe(m_sda_oe)
  );

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural slave (reference for the bus) ----------------
  byte unsigned rxq[$];
  bit           mackq[$];
  logic pscl = 1'b1, psda = 1'b1;
  logic active = 1'b0, skip = 1'b0, addr_ph = 1'b0, rdir = 1'b0;
  int   bitn = 0;
  logic [7:0] sh = '0;

  always @(scl_w or sda_w) begin
    if (pscl && scl_w && psda && !sda_w) begin
      active = 1'b1; skip = 1'b1; bitn = 0; addr_ph = 1'b1; rdir = 1'b0; s_sda_oe = 1'b0;
    end else if (pscl && scl_w && !psda && sda_w) begin
      active = 1'b0; s_sda_oe = 1'b0;
    end else if (!pscl && scl_w && active) begin
      if (bitn < 8) sh = {sh[6:0], sda_w};
      else if (rdir && !addr_ph) mackq.push_back(sda_w);
    end else if (pscl && !scl_w && active) begin
      if (skip) skip = 1'b0;
      else begin
        bitn++;
        if (bitn == 8) begin
          if (rdir && !addr_ph) s_sda_oe = 1'b0;
          else begin
            s_sda_oe = ack_en;
            rxq.push_back(sh);
            if (addr_ph) rdir = sh[0];
          end
        end else if (bitn == 9) begin
          bitn = 0;
          s_sda_oe = 1'b0;
          if (addr_ph) begin
            addr_ph = 1'b0;
            if (rdir && ack_en) s_sda_oe = ~slv_tx[7];
          end else if (rdir && mackq.size() > 0 && mackq[$] == 1'b0) begin
            s_sda_oe = ~slv_tx[7];
          end
        end else if (rdir && !addr_ph) begin
          s_sda_oe = ~slv_tx[7 - bitn];
        end
      end
    end
    pscl = scl_w;
    psda = ~(m_sda_oe | s_sda_oe | jam);
  end

  // ---------------- per-clock comparison: core off means lines released (R10)
  logic en_model = 1'b0;
  logic [2:0] en_hist = '0;
  always @(negedge clk) begin
    en_hist <= {en_hist[1:0], en_model};
    if (!rst && en_hist == 3'b000 && !en_model)
      check(!m_scl_oe && !m_sda_oe, "R10", "line driven while off",
            {m_scl_oe, m_sda_oe}, 0);
  end

  // ---------------- register access ----------------
  task automatic reg_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wd = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    we = 1'b0; addr = a;
    @(negedge clk);
    v = rdata;
  endtask

  task automatic wait_idle(output logic [7:0] st);
    st = 8'h02;
    for (int i = 0; i < 3000 && st[1]; i++) reg_read(A_CMD, st);
    if (st[1]) check(1'b0, "R6", "transfer never ended", st, 0);
  endtask

  bit wd_hit = 1'b0;
  initial begin
    #(4 * 150000);
    wd_hit = 1'b1;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int t1, t2;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    reg_read(A_CMD, v); check(v == 8'h00, "R1", "status", v, 8'h00);
    reg_read(A_CTL, v); check(v == 8'h00, "R1", "control", v, 8'h00);
    reg_read(A_LO,  v); check(v == 8'h00, "R1", "divider low", v, 8'h00);
    check(!irq && scl_w && sda_w, "R1", "irq/lines", {irq, scl_w, sda_w}, 3'b011);

    // R2 readback
    reg_write(A_HI, 8'h5A); reg_read(A_HI, v); check(v == 8'h5A, "R2", "divider high", v, 8'h5A);
    reg_write(A_HI, 8'h00);
    reg_write(A_LO, DIV);   reg_read(A_LO, v); check(v == DIV, "R2", "divider low", v, DIV);
    reg_write(A_CTL, 8'h7F); reg_read(A_CTL, v); check(v == 8'h40, "R2", "control mask", v, 8'h40);

    // R10 commands ignored while off
    reg_write(A_CTL, 8'h00);
    reg_write(A_DAT, 8'hA4);
    reg_write(A_CMD, 8'h90);
    reg_read(A_CMD, v); check(v == 8'h00, "R10", "status while off", v, 8'h00);
    repeat (40) @(negedge clk);
    check(scl_w && sda_w, "R10", "bus idle while off", {scl_w, sda_w}, 2'b11);

    // R3 R5 R6 R8 R7: START+WR address byte, slave acks
    en_model = 1'b1;
    reg_write(A_CTL, 8'hC0);
    reg_write(A_CMD, 8'h90);
    reg_read(A_CMD, v); check(v[1] == 1'b1, "R6", "tip after launch", v[1], 1);
    @(posedge scl_w); t1 = cyc;
    @(posedge scl_w); t2 = cyc;
    check(t2 - t1 == BIT_T, "R8", "SCL rise spacing", t2 - t1, BIT_T);
    wait_idle(v);
    check(v == 8'h41, "R3", "status after acked byte", v, 8'h41);
    check(rxq.size() == 1 && rxq[0] == 8'hA4, "R3", "slave got byte",
          rxq.size() > 0 ? int'(rxq[0]) : -1, 8'hA4);
    check(irq == 1'b1, "R7", "irq with ie", irq, 1);
    reg_write(A_CTL, 8'h80);
    check(irq == 1'b0, "R7", "irq masked", irq, 0);
    reg_write(A_CTL, 8'hC0);
    reg_write(A_CMD, 8'h01);
    reg_read(A_CMD, v);
    check(v[0] == 1'b0 && !irq, "R7", "iack clears", {v[0], irq}, 0);

    // R5 R6: data byte with STOP, no clearing of command bits between
    reg_write(A_DAT, 8'h3C);
    reg_write(A_CMD, 8'h50);
    wait_idle(v);
    repeat (8) @(negedge clk);
    reg_read(A_CMD, v);
    check(v == 8'h01, "R5", "not busy after stop", v, 8'h01);
    check(rxq.size() == 2 && rxq[1] == 8'h3C, "R6", "second byte accepted",
          rxq.size() > 1 ? int'(rxq[1]) : -1, 8'h3C);
    check(scl_w && sda_w, "R5", "lines released after stop", {scl_w, sda_w}, 2'b11);

    // R3 refused address
    ack_en = 1'b0;
    reg_write(A_CMD, 8'h01);
    reg_write(A_DAT, 8'h22);
    reg_write(A_CMD, 8'h90);
    wait_idle(v);
    check(v[7] == 1'b1, "R3", "rxack on refusal", v[7], 1);
    check(v[6] == 1'b1, "R5", "busy after start", v[6], 1);
    reg_write(A_CMD, 8'h41);
    wait_idle(v);
    repeat (8) @(negedge clk);
    reg_read(A_CMD, v); check(v[6] == 1'b0, "R5", "busy after lone stop", v[6], 0);
    ack_en = 1'b1;

    // R4 read two bytes: ACK then NACK with STOP
    reg_write(A_DAT, 8'hA7);
    reg_write(A_CMD, 8'h91);
    wait_idle(v);
    check(v[7] == 1'b0, "R4", "read address acked", v[7], 0);
    reg_write(A_CMD, 8'h20);
    wait_idle(v);
    reg_read(A_DAT, v); check(v == 8'h96, "R4", "first read byte", v, 8'h96);
    check(mackq.size() == 1 && mackq[0] == 1'b0, "R4", "master ack level",
          mackq.size() > 0 ? int'(mackq[0]) : -1, 0);
    reg_write(A_CMD, 8'h68);
    wait_idle(v);
    reg_read(A_DAT, v); check(v == 8'h96, "R4", "last read byte", v, 8'h96);
    check(mackq.size() == 2 && mackq[1] == 1'b1, "R4", "master nack level",
          mackq.size() > 1 ? int'(mackq[1]) : -1, 1);

    // R9 arbitration loss
    repeat (8) @(negedge clk);
    reg_write(A_CMD, 8'h01);
    reg_write(A_DAT, 8'hFF);
    reg_write(A_CMD, 8'h90);
    @(negedge scl_w);
    jam = 1'b1;
    wait_idle(v);
    check(v[5] == 1'b1 && v[0] == 1'b1, "R9", "al and ip", v, 8'h21);
    check(!m_scl_oe && !m_sda_oe, "R9", "lines released", {m_scl_oe, m_sda_oe}, 0);
    repeat (3 * BIT_T) @(negedge clk);
    check(scl_w == 1'b1, "R9", "no further clocking", scl_w, 1);
    jam = 1'b0;
    repeat (8) @(negedge clk);
    reg_write(A_CMD, 8'h01);
    reg_write(A_DAT, 8'hA4);
    reg_write(A_CMD, 8'hD0);
    wait_idle(v);
    check(v[5] == 1'b0 && v[7] == 1'b0, "R9", "al cleared by start", v, 8'h01);

    if (!wd_hit) begin
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule